// File: doc/BRIEF.md
# Pixel Clock Source Selector

This block chooses which of several candidate source clocks should drive a display pixel clock, and with what integer divider. A request carries a target frequency in kHz. The block then walks the candidates from index 0 upward. It stops at the first one whose divided output lands inside a per-mille tolerance window around the target. That window is asymmetric, for example -0.6% to +0.5% for an HDMI link.

Each candidate has three inputs: a present flag, a rate in Hz, and a settable flag. A settable source is one that can be retuned to the request, and its rate input carries the nearest rate it can reach. A source that is not settable reports its fixed rate. Every division needed during the search runs on one shared restoring divider, which produces one quotient bit per cycle.

The result is reported with a one-cycle done pulse. It gives either the winning index, the divider, the achieved rate and the rate to request from that source, or a no-match flag.

Top module: `pclk_selector`

## Requirements
- R1: Candidates are examined in ascending index order, and a source whose present bit is 0 is skipped. The lowest-index acceptable source is reported on sel_idx.
- R2: A present source whose rate equals desired_khz*1000 exactly is accepted with sel_div = 1 and sel_rate equal to its rate. This holds even when div_max is below 1.
- R3: In every other case the divider is (rate + floor(target_hz/2)) / target_hz, truncated, which is round-to-nearest. A divider of 0, or one greater than div_max, rejects the source.
- R4: The achieved rate is (rate + floor(div/2)) / div, truncated, and it is reported on sel_rate.
- R5: When the achieved rate is below target_hz, floor(achieved / desired_khz) must be at least pmil_min, or the source is rejected.
- R6: When the achieved rate is at or above target_hz, ceil(achieved / desired_khz) must not exceed pmil_max, or the source is rejected.
- R7: tune_rate equals desired_khz*1000 when the winning source's settable bit is 1. Otherwise it equals that source's rate.
- R8: When no source qualifies, done pulses with no_match = 1.
- R9: done is high for exactly one cycle per request. The result outputs change only in the cycle done is high and hold their values otherwise.
- R10: A start pulse while busy is high is ignored. The search in progress keeps the target it captured, and exactly one done follows.
- R11: After reset, busy, done, no_match, sel_idx, sel_div, sel_rate and tune_rate are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| desired_khz | input | KHZ_W | Target pixel frequency in kHz, captured at start |
| src_rate_flat | input | NUM_SRC*RATE_W | Candidate rates in Hz, source k at bits [k*RATE_W +: RATE_W] |
| src_present | input | NUM_SRC | Bit k set when source k exists |
| src_settable | input | NUM_SRC | Bit k set when source k can be tuned to the target |
| div_max | input | DIV_W | Largest allowed divider |
| pmil_min | input | PM_W | Lower per-mille bound |
| pmil_max | input | PM_W | Upper per-mille bound |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| no_match | output | 1 | Last search found no source |
| sel_idx | output | IDX_W | Winning source index |
| sel_div | output | DIV_W | Winning divider |
| sel_rate | output | RATE_W | Achieved pixel rate in Hz |
| tune_rate | output | RATE_W | Rate to program into the winning source |

## Verification
The assertions rely on three things about the inputs. desired_khz is non-zero. desired_khz*1000 fits in RATE_W bits. The per-source rates, flags, divider limit and per-mille bounds stay constant from start until done. The stimulus keeps to all three. Every input is applied on a falling edge before start is pulsed, and nothing is changed until the done pulse has been seen. The one exception is desired_khz in the ignored-start case: the block has already captured its value by then, so changing it does not break the assumption.

// File: rtl/pclk_selector.sv
module pclk_selector #(
  parameter int NUM_SRC = 4,
  parameter int RATE_W  = 32,
  parameter int KHZ_W   = 20,
  parameter int DIV_W   = 8,
  parameter int PM_W    = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [KHZ_W-1:0]          desired_khz,
  input  logic [NUM_SRC*RATE_W-1:0] src_rate_flat,
  input  logic [NUM_SRC-1:0]        src_present,
  input  logic [NUM_SRC-1:0]        src_settable,
  input  logic [DIV_W-1:0]          div_max,
  input  logic [PM_W-1:0]           pmil_min,
  input  logic [PM_W-1:0]           pmil_max,
  output logic                      busy,
  output logic                      done,
  output logic                      no_match,
  output logic [((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)-1:0] sel_idx,
  output logic [DIV_W-1:0]          sel_div,
  output logic [RATE_W-1:0]         sel_rate,
  output logic [RATE_W-1:0]         tune_rate
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int SW    = $clog2(NUM_SRC + 1);
  localparam int NW    = RATE_W + 1;
  localparam int CW    = $clog2(NW + 1);

  typedef enum logic [1:0] {S_IDLE, S_PICK, S_DIV, S_EVAL} st_t;
  typedef enum logic [1:0] {P_DIV, P_RATE, P_PMIL} ph_t;

  st_t st;
  ph_t ph;
  logic [SW-1:0]     scan;
  logic [RATE_W-1:0] dhz, rc, ach;
  logic [KHZ_W-1:0]  dkhz;
  logic [DIV_W-1:0]  dv;
  logic [NW-1:0]     dq, dd, dr;
  logic [CW-1:0]     dcnt;

  logic [RATE_W-1:0] cur_rate;
  logic              cur_pres, cur_set;
  always_comb begin
    cur_rate = '0;
    cur_pres = 1'b0;
    cur_set  = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (scan == SW'(k)) begin
        cur_rate = src_rate_flat[k*RATE_W +: RATE_W];
        cur_pres = src_present[k];
        cur_set  = src_settable[k];
      end
    end
  end

  wire [NW:0] trial   = {dr, dq[NW-1]};
  wire        fit     = trial >= {1'b0, dd};
  wire        div_bad = (dq == '0) || (dq > NW'(div_max));
  wire        below   = ach < dhz;
  wire        pm_ok   = below ? (dq >= NW'(pmil_min)) : (dq <= NW'(pmil_max));

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_DIV; scan <= '0;
      dhz <= '0; dkhz <= '0; rc <= '0; ach <= '0; dv <= '0;
      dq <= '0; dd <= '0; dr <= '0; dcnt <= '0;
      done <= 1'b0; no_match <= 1'b0;
      sel_idx <= '0; sel_div <= '0; sel_rate <= '0; tune_rate <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          dkhz <= desired_khz;
          dhz  <= RATE_W'(desired_khz) * RATE_W'(1000);
          scan <= '0;
          st   <= S_PICK;
        end
        S_PICK: begin
          if (scan == SW'(NUM_SRC)) begin
            done <= 1'b1; no_match <= 1'b1; st <= S_IDLE;
          end else if (!cur_pres) begin
            scan <= scan + 1'b1;
          end else if (cur_rate == dhz) begin
            done <= 1'b1; no_match <= 1'b0;
            sel_idx <= IDX_W'(scan); sel_div <= DIV_W'(1);
            sel_rate <= cur_rate; tune_rate <= cur_set ? dhz : cur_rate;
            st <= S_IDLE;
          end else begin
            rc <= cur_rate;
            dq <= {1'b0, cur_rate} + NW'(dhz >> 1);
            dd <= {1'b0, dhz};
            dr <= '0; dcnt <= CW'(NW - 1);
            ph <= P_DIV; st <= S_DIV;
          end
        end
        S_DIV: begin
          dq <= {dq[NW-2:0], fit};
          dr <= NW'(fit ? trial - {1'b0, dd} : trial);
          if (dcnt == '0) st <= S_EVAL;
          else dcnt <= dcnt - 1'b1;
        end
        S_EVAL: begin
          case (ph)
            P_DIV: begin
              if (div_bad) begin
                scan <= scan + 1'b1; st <= S_PICK;
              end else begin
                dv <= DIV_W'(dq);
                dq <= {1'b0, rc} + (dq >> 1);
                dd <= dq;
                dr <= '0; dcnt <= CW'(NW - 1);
                ph <= P_RATE; st <= S_DIV;
              end
            end
            P_RATE: begin
              ach <= dq[RATE_W-1:0];
              dq  <= (dq[RATE_W-1:0] < dhz) ? dq : dq + NW'(dkhz) - NW'(1);
              dd  <= NW'(dkhz);
              dr  <= '0; dcnt <= CW'(NW - 1);
              ph  <= P_PMIL; st <= S_DIV;
            end
            default: begin
              if (pm_ok) begin
                done <= 1'b1; no_match <= 1'b0;
                sel_idx <= IDX_W'(scan); sel_div <= dv;
                sel_rate <= ach; tune_rate <= cur_set ? dhz : rc;
                st <= S_IDLE;
              end else begin
                scan <= scan + 1'b1; st <= S_PICK;
              end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pclk_selector_chk.sv
module pclk_selector_chk #(
  parameter int NUM_SRC = 4,
  parameter int RATE_W  = 32,
  parameter int DIV_W   = 8,
  parameter int IDX_W   = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic [NUM_SRC*RATE_W-1:0] src_rate_flat,
  input logic [NUM_SRC-1:0]        src_present,
  input logic [NUM_SRC-1:0]        src_settable,
  input logic [DIV_W-1:0]          div_max,
  input logic                      busy,
  input logic                      done,
  input logic                      no_match,
  input logic [IDX_W-1:0]          sel_idx,
  input logic [DIV_W-1:0]          sel_div,
  input logic [RATE_W-1:0]         sel_rate,
  input logic [RATE_W-1:0]         tune_rate
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(sel_idx) && $stable(sel_div) && $stable(sel_rate) &&
               $stable(tune_rate) && $stable(no_match)));

  a_r10_busy_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  a_r1_winner_present: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_match) |-> src_present[sel_idx]);

  a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_match) |-> (sel_div != '0 && (sel_div == DIV_W'(1) || sel_div <= div_max)));

  a_r7_fixed_tune: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_match && !src_settable[sel_idx]) |->
      (tune_rate == src_rate_flat[sel_idx*RATE_W +: RATE_W]));
endmodule

bind pclk_selector pclk_selector_chk #(
  .NUM_SRC(NUM_SRC), .RATE_W(RATE_W), .DIV_W(DIV_W),
  .IDX_W((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .src_rate_flat(src_rate_flat),
  .src_present(src_present), .src_settable(src_settable), .div_max(div_max),
  .busy(busy), .done(done), .no_match(no_match), .sel_idx(sel_idx),
  .sel_div(sel_div), .sel_rate(sel_rate), .tune_rate(tune_rate)
);

// File: tb/sim_pclk_selector.sv
`timescale 1ns/1ps
module sim_pclk_selector;
  localparam int NS = 3, RW = 20, KW = 10, DW = 4, PW = 11, IW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start;
  logic [KW-1:0] desired_khz;
  logic [NS*RW-1:0] rate_flat;
  logic [NS-1:0] pres, sett;
  logic [DW-1:0] div_max;
  logic [PW-1:0] pmin, pmax;
  logic busy, done, no_match;
  logic [IW-1:0] sel_idx;
  logic [DW-1:0] sel_div;
  logic [RW-1:0] sel_rate, tune_rate;

  pclk_selector #(.NUM_SRC(NS), .RATE_W(RW), .KHZ_W(KW), .DIV_W(DW), .PM_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .desired_khz(desired_khz),
    .src_rate_flat(rate_flat), .src_present(pres), .src_settable(sett),
    .div_max(div_max), .pmil_min(pmin), .pmil_max(pmax), .busy(busy), .done(done),
    .no_match(no_match), .sel_idx(sel_idx), .sel_div(sel_div), .sel_rate(sel_rate),
    .tune_rate(tune_rate));

  int checks = 0, errors = 0;
  longint r_rate[NS];
  bit r_pres[NS], r_set[NS];
  longint r_khz, r_dmax, r_pmin, r_pmax;
  bit e_nm;
  longint e_idx, e_div, e_rate, e_tune;
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic model();
    longint dhz, rc, d, ach, pm;
    dhz = r_khz * 1000;
    e_nm = 1'b1;
    for (int i = 0; i < NS; i++) begin
      if (e_nm && r_pres[i]) begin
        rc = r_rate[i];
        if (rc == dhz) begin
          e_nm = 0; e_idx = i; e_div = 1; e_rate = rc;
          e_tune = r_set[i] ? dhz : rc;
        end else begin
          d = (rc + dhz / 2) / dhz;
          if (d != 0 && d <= r_dmax) begin
            ach = (rc + d / 2) / d;
            if (ach < dhz) pm = ach / r_khz;
            else pm = (ach + r_khz - 1) / r_khz;
            if ((ach < dhz && pm >= r_pmin) || (ach >= dhz && pm <= r_pmax)) begin
              e_nm = 0; e_idx = i; e_div = d; e_rate = ach;
              e_tune = r_set[i] ? dhz : rc;
            end
          end
        end
      end
    end
  endtask

  task automatic apply();
    desired_khz = KW'(r_khz);
    div_max = DW'(r_dmax);
    pmin = PW'(r_pmin);
    pmax = PW'(r_pmax);
    for (int i = 0; i < NS; i++) begin
      rate_flat[i*RW +: RW] = RW'(r_rate[i]);
      pres[i] = r_pres[i];
      sett[i] = r_set[i];
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 3000);
    chk(done == 1'b1, {tag, " R9 done seen"}, done, 1);
  endtask

  task automatic check_result(input string tag);
    if (e_nm) chk(no_match == 1'b1, {tag, " R8 no_match"}, no_match, 1);
    else begin
      chk(no_match == 1'b0, {tag, " R8 no_match clear"}, no_match, 0);
      chk(sel_idx == IW'(e_idx), {tag, " R1 sel_idx"}, sel_idx, e_idx);
      chk(sel_div == DW'(e_div), {tag, " R3 sel_div"}, sel_div, e_div);
      chk(sel_rate == RW'(e_rate), {tag, " R4 sel_rate"}, sel_rate, e_rate);
      chk(tune_rate == RW'(e_tune), {tag, " R7 tune_rate"}, tune_rate, e_tune);
    end
    @(negedge clk);
    chk(done == 1'b0, {tag, " R9 single pulse"}, done, 0);
    if (!e_nm) chk(sel_div == DW'(e_div), {tag, " R9 hold"}, sel_div, e_div);
  endtask

  task automatic run_case(input string tag);
    @(negedge clk);
    apply();
    model();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(tag);
    check_result(tag);
  endtask

  task automatic set3(input longint a, input longint b, input longint c,
                      input bit pa, input bit pb, input bit pc);
    r_rate[0] = a; r_rate[1] = b; r_rate[2] = c;
    r_pres[0] = pa; r_pres[1] = pb; r_pres[2] = pc;
    r_set[0] = 0; r_set[1] = 0; r_set[2] = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    r_khz = 100; r_dmax = 8; r_pmin = 994; r_pmax = 1005;
    set3(0, 0, 0, 0, 0, 0);
    apply();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !no_match, "R11 reset flags", {busy, done, no_match}, 0);
    chk(sel_idx == 0 && sel_div == 0, "R11 reset idx/div", sel_div, 0);
    chk(sel_rate == 0 && tune_rate == 0, "R11 reset rates", sel_rate, 0);

    set3(100000, 200000, 300000, 1, 1, 1);
    run_case("R2 exact");
    r_dmax = 0;
    run_case("R2 exact with div_max 0");
    chk(sel_div == 1, "R2 div one", sel_div, 1);
    r_dmax = 8;

    set3(100000, 200000, 100000, 0, 1, 1);
    run_case("R1 absent skipped");
    chk(sel_idx == 1, "R1 idx after skip", sel_idx, 1);

    set3(40000, 500000, 0, 1, 1, 0);
    run_case("R3 zero divider");
    chk(sel_idx == 1 && sel_div == 5, "R3 zero divider idx", sel_idx, 1);

    r_dmax = 4;
    set3(500000, 300000, 0, 1, 1, 0);
    run_case("R3 over div_max");
    chk(sel_idx == 1 && sel_div == 3, "R3 over div_max idx", sel_idx, 1);
    r_dmax = 8;

    set3(99400, 0, 0, 1, 0, 0);
    run_case("R5 at min bound");
    chk(!no_match && sel_rate == 99400, "R5 min accepted", sel_rate, 99400);
    set3(99399, 0, 0, 1, 0, 0);
    run_case("R5 below min bound");
    chk(no_match == 1, "R5 min rejected", no_match, 1);

    set3(100500, 0, 0, 1, 0, 0);
    run_case("R6 at max bound");
    chk(!no_match && sel_rate == 100500, "R6 max accepted", sel_rate, 100500);
    set3(100501, 0, 0, 1, 0, 0);
    run_case("R6 above max bound");
    chk(no_match == 1, "R6 max rejected", no_match, 1);

    r_khz = 125;
    set3(250001, 0, 0, 1, 0, 0);
    run_case("R4 rounded achieved");
    chk(sel_rate == 125001 && sel_div == 2, "R4 achieved value", sel_rate, 125001);
    r_khz = 100;

    set3(100000, 0, 0, 1, 0, 0); r_set[0] = 1;
    run_case("R7 settable");
    chk(tune_rate == 100000, "R7 settable tune", tune_rate, 100000);
    set3(200000, 0, 0, 1, 0, 0); r_set[0] = 0;
    run_case("R7 fixed");
    chk(tune_rate == 200000, "R7 fixed tune", tune_rate, 200000);

    set3(100000, 100000, 100000, 0, 0, 0);
    run_case("R8 none present");
    set3(150000, 20000, 1000000, 1, 1, 1);
    run_case("R8 all rejected");

    begin
      int ndone = 0;
      r_khz = 100;
      set3(130000, 40000, 300000, 1, 1, 1);
      @(negedge clk);
      apply();
      model();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      desired_khz = KW'(150);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10 still busy", busy, 1);
      wait_done("R10 ignored start");
      ndone = 1;
      check_result("R10 ignored start");
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (done) ndone++;
      end
      chk(ndone == 1, "R10 one done only", ndone, 1);
      chk(busy == 1'b0, "R10 idle after", busy, 0);
    end

    for (int t = 0; t < 300; t++) begin
      longint dhz, base, span;
      r_khz = 20 + rnd() % 81;
      dhz = r_khz * 1000;
      r_dmax = 1 + rnd() % 12;
      r_pmin = 988 + rnd() % 10;
      r_pmax = 1000 + rnd() % 10;
      for (int i = 0; i < NS; i++) begin
        base = dhz * (1 + rnd() % 9);
        span = base / 100;
        r_rate[i] = base + longint'(rnd() % (2 * span + 1)) - span;
        if (rnd() % 5 == 0) r_rate[i] = rnd() % 1048576;
        if (rnd() % 6 == 0) r_rate[i] = dhz;
        r_pres[i] = (rnd() % 5) != 0;
        r_set[i] = rnd() % 2;
      end
      run_case("R1 sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule